// File: doc/BRIEF.md
# Pattern Word Decompressor

This block rebuilds a 512-bit line from a compressed buffer. The buffer opens with sixteen 4-bit pattern codes, one for each 32-bit word of the line. Packed payloads follow the codes. The length of each payload depends only on its code. A chain of cascaded adders turns these lengths into the bit offset of each payload, and it also gives the total compressed size. No size field is stored.

Once the offsets are known, all sixteen words are decoded in parallel. Literal patterns expand their payload by sign-extension, by shifting or by replication. Dictionary patterns copy the word one or two positions earlier, and two of them also splice in a new low byte or a new low halfword. A reverse input lets the caller pass a block that was written backwards from the far end of a slot. The block then reverses the buffer bit by bit before decoding it.

A caller pulses `start_i` with the buffer. Two clocks later `done_o` pulses, and the line, the size and the error flag are then valid. A new start is accepted on every cycle.

Top module: `pattern_word_decomp`

## Requirements
- R1: When `start_i` is sampled high at a clock edge, `done_o` is high for exactly one cycle after the second edge that follows. A start is accepted on every cycle, and results come out in the order they were issued.
- R2: The code of word i sits at buffer bits [4i+3:4i]. Payloads are packed from bit 64 upward in word order, each one least significant bit first. In `line_o`, word i is bits [32i+31:32i].
- R3: `size_o` equals 64 plus the sum of the payload lengths, counted in bits.
- R4: The literal codes decode as follows. Code 0 gives zero, with no payload. Code 1 sign-extends a 4-bit payload. Code 2 sign-extends an 8-bit payload. Code 3 sign-extends a 16-bit payload. Code 4 places a 16-bit payload in the upper half, with the lower half zero. Code 5 takes a 16-bit payload and sign-extends each of its two bytes into a halfword. Code 6 repeats an 8-bit payload in all four bytes. Code 7 is a raw 32-bit word.
- R5: The dictionary codes decode as follows. Code 8 copies the decoded word i-1 and code 9 copies the decoded word i-2, neither with a payload. Codes 10 and 11 take word i-1 and word i-2 and replace the low byte with an 8-bit payload. Codes 12 and 13 take word i-1 and word i-2 and replace the low halfword with a 16-bit payload.
- R6: A reference to a word before word 0 reads as zero.
- R7: Codes 14 and 15 are reserved. Each decodes to zero with no payload, and `err_o` is then set with that result.
- R8: When `rev_i` is high, buffer bit j is taken from `buf_i` bit 511-j.
- R9: Payload bits that lie past bit 511 read as zero.
- R10: While reset is held, `done_o`, `line_o`, `size_o` and `err_o` are all zero.
- R11: Between `done_o` pulses, `line_o`, `size_o` and `err_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin decoding `buf_i` |
| rev_i | input | 1 | The buffer is stored in reversed bit order |
| buf_i | input | 512 | Compressed buffer |
| done_o | output | 1 | One-cycle pulse when a result is valid |
| line_o | output | 512 | Decoded sixteen-word line |
| size_o | output | 10 | Compressed size in bits |
| err_o | output | 1 | A reserved code was present |

## Verification
The offset and size computation for a newly started buffer falls in the same cycle as the word decode of the buffer started one cycle earlier. Runs of starts on consecutive cycles provoke this overlap, with the reverse input changing from one buffer to the next. A scoreboard judges each result in issue order. It checks the cycle in which the result arrives and compares the line, the size and the error flag with a model that walks the buffer bit by bit. Idle gaps between bursts confirm that the outputs hold between results.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  typedef enum logic [3:0] {
    C_ZERO, C_S4, C_S8, C_S16, C_HI16, C_HALF8, C_REPB, C_RAW,
    C_P1, C_P2, C_P1B, C_P2B, C_P1H, C_P2H, C_RSV0, C_RSV1
  } pcode_e;

  // payload length in bits for each code (R3, R4, R5, R7)
  function automatic logic [5:0] pay_len(logic [3:0] c);
    case (pcode_e'(c))
      C_S4:                                  pay_len = 6'd4;
      C_S8, C_REPB, C_P1B, C_P2B:            pay_len = 6'd8;
      C_S16, C_HI16, C_HALF8, C_P1H, C_P2H:  pay_len = 6'd16;
      C_RAW:                                 pay_len = 6'd32;
      default:                               pay_len = 6'd0;
    endcase
  endfunction

  function automatic logic is_rsv(logic [3:0] c);
    return (pcode_e'(c) == C_RSV0) || (pcode_e'(c) == C_RSV1);
  endfunction

  // word expansion: p = payload (LSB aligned), d1/d2 = previous decoded words
  function automatic logic [31:0] expand(logic [3:0] c, logic [31:0] p,
                                         logic [31:0] d1, logic [31:0] d2);
    case (pcode_e'(c))
      C_S4:    expand = {{28{p[3]}}, p[3:0]};
      C_S8:    expand = {{24{p[7]}}, p[7:0]};
      C_S16:   expand = {{16{p[15]}}, p[15:0]};
      C_HI16:  expand = {p[15:0], 16'h0000};
      C_HALF8: expand = {{8{p[15]}}, p[15:8], {8{p[7]}}, p[7:0]};
      C_REPB:  expand = {4{p[7:0]}};
      C_RAW:   expand = p;
      C_P1:    expand = d1;
      C_P2:    expand = d2;
      C_P1B:   expand = {d1[31:8], p[7:0]};
      C_P2B:   expand = {d2[31:8], p[7:0]};
      C_P1H:   expand = {d1[31:16], p[15:0]};
      C_P2H:   expand = {d2[31:16], p[15:0]};
      default: expand = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/pwd_offsets.sv
module pwd_offsets import pwd_pkg::*; #(
  parameter int N_WORDS = 16,
  parameter int CODE_W  = 4,
  parameter int OFF_W   = 10,
  localparam int HDR_W  = N_WORDS * CODE_W,
  localparam int MAX_SZ = HDR_W + N_WORDS * 32
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [HDR_W-1:0]                  hdr,
  output logic [N_WORDS-1:0][OFF_W-1:0]     off,
  output logic [OFF_W-1:0]                  total
);

  logic [OFF_W-1:0] acc [N_WORDS+1];

  assign acc[0] = OFF_W'(HDR_W);

  for (genvar i = 0; i < N_WORDS; i++) begin : g_chain
    assign acc[i+1] = acc[i] + OFF_W'(pay_len(hdr[i*CODE_W +: CODE_W]));
    assign off[i]   = acc[i];
  end

  assign total = acc[N_WORDS];

  p_total_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (total >= OFF_W'(HDR_W)) && (total <= OFF_W'(MAX_SZ)));

endmodule

// File: rtl/pwd_decode.sv
module pwd_decode import pwd_pkg::*; #(
  parameter int BUF_W   = 512,
  parameter int N_WORDS = 16,
  parameter int CODE_W  = 4,
  parameter int OFF_W   = 10,
  localparam int LINE_W = N_WORDS * 32
)(
  input  logic [BUF_W-1:0]                  buf_q,
  input  logic [N_WORDS-1:0][OFF_W-1:0]     off,
  output logic [LINE_W-1:0]                 line,
  output logic                              err
);

  logic [31:0]        dec [N_WORDS];
  logic [31:0]        d1  [N_WORDS];
  logic [31:0]        d2  [N_WORDS];
  logic [N_WORDS-1:0] rsv;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    logic [CODE_W-1:0] code;
    logic [BUF_W-1:0]  shifted;
    assign code    = buf_q[i*CODE_W +: CODE_W];
    assign shifted = buf_q >> off[i];          // bits past the end shift in as zero
    if (i == 0) begin : g_r0
      assign d1[i] = 32'h0;
      assign d2[i] = 32'h0;
    end else if (i == 1) begin : g_r1
      assign d1[i] = dec[i-1];
      assign d2[i] = 32'h0;
    end else begin : g_rn
      assign d1[i] = dec[i-1];
      assign d2[i] = dec[i-2];
    end
    assign dec[i]           = expand(code, shifted[31:0], d1[i], d2[i]);
    assign rsv[i]           = is_rsv(code);
    assign line[i*32 +: 32] = dec[i];
  end

  assign err = |rsv;

endmodule

// File: rtl/pattern_word_decomp.sv
module pattern_word_decomp #(
  parameter int BUF_W   = 512,
  parameter int N_WORDS = 16,
  parameter int CODE_W  = 4,
  localparam int HDR_W  = N_WORDS * CODE_W,
  localparam int LINE_W = N_WORDS * 32,
  localparam int OFF_W  = $clog2(HDR_W + LINE_W + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rev_i,
  input  logic [BUF_W-1:0]  buf_i,
  output logic              done_o,
  output logic [LINE_W-1:0] line_o,
  output logic [OFF_W-1:0]  size_o,
  output logic              err_o
);

  // input orientation (R8)
  logic [BUF_W-1:0] fwd_buf;
  for (genvar j = 0; j < BUF_W; j++) begin : g_rev
    assign fwd_buf[j] = rev_i ? buf_i[BUF_W-1-j] : buf_i[j];
  end

  // stage 1: offsets and size from header
  logic [N_WORDS-1:0][OFF_W-1:0] off_c, off_q;
  logic [OFF_W-1:0]              total_c, size_q;
  logic [BUF_W-1:0]              buf_q;
  logic                          ofs_valid;

  pwd_offsets #(.N_WORDS(N_WORDS), .CODE_W(CODE_W), .OFF_W(OFF_W)) u_ofs (
    .clk   (clk),
    .rst_n (rst_n),
    .hdr   (fwd_buf[HDR_W-1:0]),
    .off   (off_c),
    .total (total_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_valid <= 1'b0;
      buf_q     <= '0;
      off_q     <= '0;
      size_q    <= '0;
    end else begin
      ofs_valid <= start_i;
      if (start_i) begin
        buf_q  <= fwd_buf;
        off_q  <= off_c;
        size_q <= total_c;
      end
    end
  end

  // stage 2: parallel word decode
  logic [LINE_W-1:0] line_c;
  logic              err_c;
  logic              dec_fire;

  pwd_decode #(.BUF_W(BUF_W), .N_WORDS(N_WORDS), .CODE_W(CODE_W), .OFF_W(OFF_W)) u_dec (
    .buf_q (buf_q),
    .off   (off_q),
    .line  (line_c),
    .err   (err_c)
  );

  assign dec_fire = ofs_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      line_o <= '0;
      size_o <= '0;
      err_o  <= 1'b0;
    end else begin
      done_o <= dec_fire;
      if (dec_fire) begin
        line_o <= line_c;
        size_o <= size_q;
        err_o  <= err_c;
      end
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ofs_valid);
  p_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> done_o);
  p_done_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ofs_valid));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_fire |=> ($stable(line_o) && $stable(size_o) && $stable(err_o)));
  p_size_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (size_o >= OFF_W'(HDR_W)));

endmodule

// File: tb/pattern_word_decomp_tb.sv
`timescale 1ns/1ps
module pattern_word_decomp_tb;

  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0, rev = 1'b0;
  logic [511:0] bufv = '0;
  logic         done, err;
  logic [511:0] line;
  logic [9:0]   size;

  pattern_word_decomp u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rev_i(rev), .buf_i(bufv),
    .done_o(done), .line_o(line), .size_o(size), .err_o(err)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [511:0] line;
    int           size;
    bit           err;
    int           due;
    string        tag;
  } exp_t;

  exp_t         q[$];
  exp_t         cur;
  int           checks = 0, errors = 0, cyc = 0;
  bit           seen = 0;
  logic [511:0] last_line;
  logic [9:0]   last_size;
  logic         last_err;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic int blen(int c);
    case (c)
      1: return 4;
      2, 6, 10, 11: return 8;
      3, 4, 5, 12, 13: return 16;
      7: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] sx(logic [31:0] v, int n);
    logic signed [31:0] t;
    t = $signed(v << (32 - n));
    return t >>> (32 - n);
  endfunction

  function automatic logic [511:0] revb(logic [511:0] b);
    logic [511:0] r;
    for (int j = 0; j < 512; j++) r[j] = b[511-j];
    return r;
  endfunction

  // reference model: walks the forward-order buffer bit by bit (R2..R9)
  function automatic exp_t model(logic [511:0] b);
    exp_t        r;
    int          ptr = 64;
    logic [31:0] w[16];
    logic [31:0] p, a1, a2, hi, lo;
    r.line = '0; r.err = 0;
    for (int i = 0; i < 16; i++) begin
      int c = int'(b[4*i +: 4]);
      p = '0;
      for (int k = 0; k < blen(c); k++) if (ptr + k < 512) p[k] = b[ptr+k];
      ptr += blen(c);
      a1 = (i > 0) ? w[i-1] : 32'h0;
      a2 = (i > 1) ? w[i-2] : 32'h0;
      case (c)
        1: w[i] = sx(p, 4);
        2: w[i] = sx(p, 8);
        3: w[i] = sx(p, 16);
        4: w[i] = p << 16;
        5: begin hi = sx(p >> 8, 8); lo = sx(p, 8); w[i] = {hi[15:0], lo[15:0]}; end
        6: w[i] = p[7:0] * 32'h01010101;
        7: w[i] = p;
        8: w[i] = a1;
        9: w[i] = a2;
        10: w[i] = (a1 & ~32'hFF) | p;
        11: w[i] = (a2 & ~32'hFF) | p;
        12: w[i] = (a1 & ~32'hFFFF) | p;
        13: w[i] = (a2 & ~32'hFFFF) | p;
        14, 15: begin w[i] = 32'h0; r.err = 1; end
        default: w[i] = 32'h0;
      endcase
      r.line[32*i +: 32] = w[i];
    end
    r.size = ptr;
    return r;
  endfunction

  function automatic logic [511:0] pack(int cs[16], logic [31:0] ps[16]);
    logic [511:0] b = '0;
    int ptr = 64;
    for (int i = 0; i < 16; i++) begin
      b[4*i +: 4] = 4'(cs[i]);
      for (int k = 0; k < blen(cs[i]); k++) if (ptr + k < 512) b[ptr+k] = ps[i][k];
      ptr += blen(cs[i]);
    end
    return b;
  endfunction

  // driver: pushes the expected item, then drives the start
  task automatic send(logic [511:0] f, bit r, string tag);
    exp_t e;
    @(negedge clk);
    e = model(f);
    e.due = cyc + 2;
    e.tag = tag;
    q.push_back(e);
    start = 1'b1;
    rev   = r;
    bufv  = r ? revb(f) : f;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      bufv  = $urandom;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (q.size() == 0) chk(0, "R1 done with no pending start", 1, 0);
        else begin
          cur = q.pop_front();
          chk(cyc == cur.due, {cur.tag, " R1 latency"}, cyc, cur.due);
          chk(line == cur.line, {cur.tag, " line"}, line, cur.line);
          chk(int'(size) == cur.size, {cur.tag, " R3 size"}, size, cur.size);
          chk(err == cur.err, {cur.tag, " R7 err"}, err, cur.err);
        end
        seen = 1; last_line = line; last_size = size; last_err = err;
      end else if (seen) begin
        chk(line == last_line && size == last_size && err == last_err,
            "R11 hold between results", {size, err}, {last_size, last_err});
      end
    end
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int          cs[16];
    logic [31:0] ps[16];
    logic [511:0] lit, dict;

    repeat (3) @(negedge clk);
    chk(done == 0 && line == '0 && size == 0 && err == 0, "R10 reset state",
        {size, err, done}, 0);
    rst_n = 1'b1;
    idle(2);

    send('0, 0, "R2 R3 R4 all-zero");
    idle(3);

    cs = '{1, 2, 3, 4, 5, 6, 7, 0, 1, 2, 3, 4, 5, 6, 7, 0};
    ps = '{32'h8, 32'h80, 32'h8000, 32'h1234, 32'h80FF, 32'hA5, 32'hDEADBEEF, 0,
           32'h7, 32'h7F, 32'h7FFF, 32'hFFFF, 32'h7F80, 32'h3C, 32'h01234567, 0};
    lit = pack(cs, ps);
    send(lit, 0, "R2 R4 literals");
    idle(2);

    cs = '{8, 9, 7, 8, 9, 10, 11, 12, 13, 8, 2, 9, 0, 11, 13, 6};
    ps = '{0, 0, 32'hCAFEF00D, 0, 0, 32'h11, 32'h22, 32'h3333, 32'h4444, 0,
           32'hF0, 0, 0, 32'h55, 32'h6666, 32'h77};
    dict = pack(cs, ps);
    send(dict, 0, "R5 R6 dictionary");
    idle(2);

    cs = '{7, 1, 2, 14, 7, 3, 8, 6, 2, 15, 7, 9, 1, 4, 5, 7};
    ps = '{32'h11111111, 32'h5, 32'h81, 0, 32'h22222222, 32'h9000, 0, 32'h3E, 32'h40,
           0, 32'h33333333, 0, 32'hF, 32'hABCD, 32'h7F01, 32'h44444444};
    send(pack(cs, ps), 0, "R7 reserved codes");
    idle(2);

    for (int i = 0; i < 16; i++) begin cs[i] = 7; ps[i] = 32'h11111111 * (i + 1); end
    send(pack(cs, ps), 0, "R3 R9 full raw overflow");
    idle(2);

    send(lit, 1, "R8 reversed literals");
    send(dict, 1, "R8 R5 reversed dictionary");
    send(lit, 0, "R1 R8 mode switch");
    idle(3);

    // bursts of back-to-back starts: stage-1 and stage-2 overlap
    for (int burst = 0; burst < 6; burst++) begin
      for (int n = 0; n < 8; n++) begin
        logic [511:0] rb;
        for (int k = 0; k < 16; k++) rb[32*k +: 32] = $urandom;
        send(rb, 1'($urandom), "R1 R2 R9 pipelined random");
      end
      idle(1 + burst);
    end

    idle(5);
    chk(q.size() == 0, "R1 results missing", q.size(), 0);
    summary();
    $finish;
  end

endmodule